// File: doc/BRIEF.md
# Packed Signed SIMD Add/Subtract Unit

This unit performs lane-parallel signed addition and subtraction on two packed operands. A 3-bit opcode selects the lane layout. Two lanes of half the operand width can be added or subtracted, or they can be combined crosswise with the opposite half of the second operand. Four byte lanes can be added or subtracted. Each lane's operands are sign-extended by one bit before the arithmetic. The lane result is truncated into the packed output. A per-byte flag vector records whether each full-precision lane result is zero or positive.

An issuing pipeline presents one operation per cycle with a valid strobe, a 4-bit condition code and a condition-pass bit from its flag logic. The result and the flags are registered, so they appear one cycle after issue together with a result-valid pulse. An operation whose condition fails, or whose opcode is unassigned, still produces the valid pulse so that the issuer can retire it. In that case the result and flag registers keep their old contents.

Top module: `simd_addsub`

## Requirements
- R1: Opcode 0 writes result[15:0] = A[15:0] + B[15:0] and result[31:16] = A[31:16] + B[31:16].
- R2: Opcode 1 writes result[15:0] = A[15:0] − B[31:16] and result[31:16] = A[31:16] + B[15:0].
- R3: Opcode 2 writes result[15:0] = A[15:0] + B[31:16] and result[31:16] = A[31:16] − B[15:0].
- R4: Opcode 3 writes result[15:0] = A[15:0] − B[15:0] and result[31:16] = A[31:16] − B[31:16].
- R5: Opcode 4 adds the byte lanes pairwise, with byte lane i at result bits [8i+7:8i].
- R6: Opcode 7 subtracts the byte lanes pairwise (A minus B), using the same lane placement as R5.
- R7: A lane flag is 1 when the sign-extended, untruncated lane result (17 bits for halfwords, 9 bits for bytes) is zero or positive, and 0 when it is negative.
- R8: For opcodes 0–3, the low halfword's flag drives flag bits 0 and 1, and the high halfword's flag drives bits 2 and 3. For opcodes 4 and 7, flag bit i comes from byte lane i.
- R9: Condition code 4'hE executes regardless of cond_pass_i. Any other code executes only when cond_pass_i is 1.
- R10: When the condition fails, or the opcode is 5 or 6, result_o and ge_o keep their previous values, while valid_o still pulses.
- R11: valid_o equals valid_i one clock later. When valid_i is 0, result_o and ge_o do not change.
- R12: An active-low asynchronous reset clears result_o, ge_o and valid_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation issue strobe |
| op_i | input | 3 | Operation select (0–4, 7 defined) |
| cond_i | input | 4 | Condition code, 4'hE = always |
| cond_pass_i | input | 1 | External condition evaluation result |
| a_i | input | 32 | First packed operand |
| b_i | input | 32 | Second packed operand |
| result_o | output | 32 | Registered packed result |
| ge_o | output | 4 | Registered per-byte greater-or-equal flags |
| valid_o | output | 1 | Result valid, one cycle after issue |

## Verification
The properties assume that every input carries a known value at each rising edge. They also assume that valid_i is low whenever the bound properties first arm, which is the first full cycle after reset is released. The bench meets these assumptions by driving every input only on falling edges and holding them at zero throughout reset. Random opcodes cover the two unassigned codes. Random condition codes hit 4'hE both with and without cond_pass_i, so the hold and always-execute paths are taken under the same stream that the reference model scores on every cycle.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

  typedef enum logic [2:0] {
    OP_ADD_H  = 3'd0,
    OP_XADD_H = 3'd1,
    OP_XSUB_H = 3'd2,
    OP_SUB_H  = 3'd3,
    OP_ADD_B  = 3'd4,
    OP_RSV_5  = 3'd5,
    OP_RSV_6  = 3'd6,
    OP_SUB_B  = 3'd7
  } simd_op_e;

  localparam logic [3:0] COND_ALWAYS = 4'hE;

  typedef struct packed {
    logic legal;
    logic byte_mode;
    logic byte_sub;
    logic xchg;
    logic lo_sub;
    logic hi_sub;
  } simd_ctrl_t;

endpackage

// File: rtl/simd_op_decode.sv
module simd_op_decode
  import simd_addsub_pkg::*;
(
  input  logic [2:0] op_i,
  output simd_ctrl_t ctrl_o
);

  simd_op_e op;
  assign op = simd_op_e'(op_i);

  always_comb begin
    ctrl_o = '0;
    unique case (op)
      OP_ADD_H:  begin ctrl_o.legal = 1'b1; end
      OP_XADD_H: begin ctrl_o.legal = 1'b1; ctrl_o.xchg = 1'b1; ctrl_o.lo_sub = 1'b1; end
      OP_XSUB_H: begin ctrl_o.legal = 1'b1; ctrl_o.xchg = 1'b1; ctrl_o.hi_sub = 1'b1; end
      OP_SUB_H:  begin ctrl_o.legal = 1'b1; ctrl_o.lo_sub = 1'b1; ctrl_o.hi_sub = 1'b1; end
      OP_ADD_B:  begin ctrl_o.legal = 1'b1; ctrl_o.byte_mode = 1'b1; end
      OP_SUB_B:  begin ctrl_o.legal = 1'b1; ctrl_o.byte_mode = 1'b1; ctrl_o.byte_sub = 1'b1; end
      default:   ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         ge_o
);

  // one guard bit holds any sum or difference of two W-bit signed values
  logic signed [W:0] x_ext, y_ext, full;

  assign x_ext = $signed({x_i[W-1], x_i});
  assign y_ext = $signed({y_i[W-1], y_i});
  assign full  = sub_i ? (x_ext - y_ext) : (x_ext + y_ext);
  assign res_o = full[W-1:0];
  assign ge_o  = ~full[W];

endmodule

// File: rtl/simd_half_path.sv
module simd_half_path
  import simd_addsub_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned HW    = DATA_W / 2,
  localparam int unsigned NB    = DATA_W / 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  simd_ctrl_t        ctrl_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NB-1:0]     ge_o
);

  logic [HW-1:0] b_for_lo, b_for_hi, res_lo, res_hi;
  logic          ge_lo, ge_hi;

  assign b_for_lo = ctrl_i.xchg ? b_i[DATA_W-1:HW] : b_i[HW-1:0];
  assign b_for_hi = ctrl_i.xchg ? b_i[HW-1:0]      : b_i[DATA_W-1:HW];

  simd_lane_addsub #(.W(HW)) u_lo (
    .x_i(a_i[HW-1:0]), .y_i(b_for_lo), .sub_i(ctrl_i.lo_sub),
    .res_o(res_lo), .ge_o(ge_lo)
  );

  simd_lane_addsub #(.W(HW)) u_hi (
    .x_i(a_i[DATA_W-1:HW]), .y_i(b_for_hi), .sub_i(ctrl_i.hi_sub),
    .res_o(res_hi), .ge_o(ge_hi)
  );

  assign res_o = {res_hi, res_lo};
  assign ge_o  = {{(NB/2){ge_hi}}, {(NB/2){ge_lo}}};

endmodule

// File: rtl/simd_byte_path.sv
module simd_byte_path #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NB    = DATA_W / 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NB-1:0]     ge_o
);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    simd_lane_addsub #(.W(8)) u_lane (
      .x_i(a_i[8*i +: 8]), .y_i(b_i[8*i +: 8]), .sub_i(sub_i),
      .res_o(res_o[8*i +: 8]), .ge_o(ge_o[i])
    );
  end

endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_addsub_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NB    = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [3:0]        cond_i,
  input  logic              cond_pass_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic [NB-1:0]     ge_o,
  output logic              valid_o
);

  simd_ctrl_t        ctrl;
  logic [DATA_W-1:0] half_res, byte_res, res_d;
  logic [NB-1:0]     half_ge, byte_ge, ge_d;
  logic              exec;

  simd_op_decode u_dec (.op_i(op_i), .ctrl_o(ctrl));

  simd_half_path #(.DATA_W(DATA_W)) u_half (
    .a_i(a_i), .b_i(b_i), .ctrl_i(ctrl), .res_o(half_res), .ge_o(half_ge)
  );

  simd_byte_path #(.DATA_W(DATA_W)) u_byte (
    .a_i(a_i), .b_i(b_i), .sub_i(ctrl.byte_sub), .res_o(byte_res), .ge_o(byte_ge)
  );

  assign res_d = ctrl.byte_mode ? byte_res : half_res;
  assign ge_d  = ctrl.byte_mode ? byte_ge  : half_ge;
  assign exec  = valid_i && ctrl.legal && ((cond_i == COND_ALWAYS) || cond_pass_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      ge_o     <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (exec) begin
        result_o <= res_d;
        ge_o     <= ge_d;
      end
    end
  end

endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NB    = DATA_W / 8,
  localparam int unsigned HW    = DATA_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [3:0]        cond_i,
  input logic              cond_pass_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] result_o,
  input logic [NB-1:0]     ge_o,
  input logic              valid_o
);

  logic armed_q;
  logic go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign go = valid_i && ((cond_i == 4'hE) || cond_pass_i);

  a_r11_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (valid_o == $past(valid_i)));

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$past(valid_i)) |-> ($stable(result_o) && $stable(ge_o)));

  a_r10_reserved_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(valid_i) && (($past(op_i) == 3'd5) || ($past(op_i) == 3'd6)))
      |-> ($stable(result_o) && $stable(ge_o) && valid_o));

  a_r9_cond_fail_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(valid_i) && ($past(cond_i) != 4'hE) && !$past(cond_pass_i))
      |-> ($stable(result_o) && $stable(ge_o)));

  a_r8_half_flag_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(go) && !$past(op_i[2]))
      |-> ((ge_o[0] == ge_o[1]) && (ge_o[NB-1] == ge_o[NB-2])));

  a_r1_add_halves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(go) && ($past(op_i) == 3'd0))
      |-> (result_o == {$past(a_i[DATA_W-1:HW] + b_i[DATA_W-1:HW]),
                        $past(a_i[HW-1:0] + b_i[HW-1:0])}));

endmodule

bind simd_addsub simd_addsub_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .cond_i(cond_i), .cond_pass_i(cond_pass_i), .a_i(a_i), .b_i(b_i),
  .result_o(result_o), .ge_o(ge_o), .valid_o(valid_o)
);

// File: tb/simd_addsub_bench.sv
module simd_addsub_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [3:0]  cond_i = '0;
  logic        cond_pass_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [31:0] result_o;
  logic [3:0]  ge_o;
  logic        valid_o;

  logic [31:0] exp_res = '0;
  logic [3:0]  exp_ge = '0;
  logic        exp_valid = 1'b0;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk_i = ~clk_i;

  simd_addsub u_simd_addsub (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .cond_i(cond_i), .cond_pass_i(cond_pass_i), .a_i(a_i), .b_i(b_i),
    .result_o(result_o), .ge_o(ge_o), .valid_o(valid_o)
  );

  function automatic integer sx16(input logic [15:0] x);
    integer r;
    r = $signed(x);
    return r;
  endfunction

  function automatic integer sx8(input logic [7:0] x);
    integer r;
    r = $signed(x);
    return r;
  endfunction

  task automatic model(input logic v, input logic [2:0] op, input logic [3:0] cond,
                       input logic pass, input logic [31:0] a, input logic [31:0] b);
    integer lo, hi;
    exp_valid = v;
    if (!v || !(cond == 4'hE || pass) || op == 3'd5 || op == 3'd6) return;
    if (op < 3'd4) begin
      case (op)
        3'd0: begin lo = sx16(a[15:0]) + sx16(b[15:0]);  hi = sx16(a[31:16]) + sx16(b[31:16]); end
        3'd1: begin lo = sx16(a[15:0]) - sx16(b[31:16]); hi = sx16(a[31:16]) + sx16(b[15:0]);  end
        3'd2: begin lo = sx16(a[15:0]) + sx16(b[31:16]); hi = sx16(a[31:16]) - sx16(b[15:0]);  end
        default: begin lo = sx16(a[15:0]) - sx16(b[15:0]); hi = sx16(a[31:16]) - sx16(b[31:16]); end
      endcase
      exp_res = {hi[15:0], lo[15:0]};
      exp_ge  = {(hi >= 0), (hi >= 0), (lo >= 0), (lo >= 0)};
    end else begin
      for (int i = 0; i < 4; i++) begin
        integer s;
        s = (op == 3'd4) ? sx8(a[8*i +: 8]) + sx8(b[8*i +: 8])
                         : sx8(a[8*i +: 8]) - sx8(b[8*i +: 8]);
        exp_res[8*i +: 8] = s[7:0];
        exp_ge[i] = (s >= 0);
      end
    end
  endtask

  task automatic compare(input string tag);
    n_cmp++;
    if (result_o !== exp_res || ge_o !== exp_ge || valid_o !== exp_valid) begin
      n_bad++;
      $display("FAIL %s: res=%h ge=%b v=%b expected res=%h ge=%b v=%b",
               tag, result_o, ge_o, valid_o, exp_res, exp_ge, exp_valid);
    end
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic step(input logic v, input logic [2:0] op, input logic [3:0] cond,
                      input logic pass, input logic [31:0] a, input logic [31:0] b,
                      input string tag);
    valid_i = v; op_i = op; cond_i = cond; cond_pass_i = pass; a_i = a; b_i = b;
    model(v, op, cond, pass, a, b);
    @(negedge clk_i);
    compare(tag);
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd7: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare("R12 reset state");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R11 idle after reset");

    step(1, 3'd0, 4'hE, 0, 32'h0001_7FFF, 32'h0001_0001, "R1 add halves");
    step(1, 3'd1, 4'hE, 0, 32'h1000_0005, 32'h0003_0007, "R2 exchange add/sub");
    step(1, 3'd2, 4'hE, 0, 32'h1000_0005, 32'h0003_0007, "R3 exchange sub/add");
    step(1, 3'd3, 4'hE, 0, 32'h0000_8000, 32'h0000_0001, "R4 R7 0x8000-1 flag negative");
    step(1, 3'd4, 4'hE, 0, 32'h0000_007F, 32'h0000_0001, "R5 R7 0x7F+1 flag positive");
    step(1, 3'd4, 4'hE, 0, 32'h8000_0080, 32'h8001_0080, "R5 R8 byte lanes -256");
    step(1, 3'd7, 4'hE, 0, 32'h7F00_0180, 32'hFF01_0001, "R6 R8 byte sub lanes");
    step(1, 3'd0, 4'h3, 1, 32'h1234_5678, 32'h1111_1111, "R9 cond pass");
    step(1, 3'd3, 4'h3, 0, 32'hFFFF_FFFF, 32'h0000_0001, "R9 cond fail holds");
    step(1, 3'd7, 4'hE, 0, 32'h0000_0000, 32'h0101_0101, "R9 always ignores pass");
    step(1, 3'd5, 4'hE, 1, 32'hAAAA_AAAA, 32'h5555_5555, "R10 opcode 5 holds");
    step(1, 3'd6, 4'hE, 1, 32'hAAAA_AAAA, 32'h5555_5555, "R10 opcode 6 holds");
    step(0, 3'd0, 4'hE, 1, 32'hDEAD_BEEF, 32'h1234_5678, "R11 no valid no change");
    step(1, 3'd0, 4'hE, 0, 32'h8000_8000, 32'h8000_8000, "R7 R8 halves -65536");

    for (int k = 0; k < 600; k++) begin
      logic [2:0] op;
      logic [3:0] cond;
      op   = 3'($urandom_range(0, 7));
      cond = ($urandom_range(0, 2) == 0) ? 4'hE : 4'($urandom);
      step(1'($urandom_range(0, 5) != 0), op, cond, 1'($urandom),
           $urandom, $urandom, op_tag(op));
    end

    rst_ni = 1'b0;
    exp_res = '0; exp_ge = '0; exp_valid = 1'b0;
    valid_i = 1'b0;
    @(negedge clk_i);
    compare("R12 mid-run reset");
    summary();
  end

endmodule